// File: doc/BRIEF.md
# Clocked front end for an asynchronous static RAM

This block lets synchronous logic use an asynchronous 16-bit static RAM. A requester offers one access at a time over a valid/ready handshake. The access carries a word address, write data, two byte-lane enables and a direction flag. The block then drives the memory's active-low chip select, write strobe, output enable and per-lane selects, and it owns the shared bidirectional data bus while writing. Read data comes back on a one-cycle response strobe.

Every phase of an access lasts a fixed number of clock cycles. Each count is worked out at elaboration as the nanosecond limit divided by the clock period, rounded up, and never less than one cycle. The nanosecond limits come from a speed-grade parameter: grade 0 is the 70 ns part, grade 1 the 85 ns part and grade 2 the 100 ns part.

- **Reads** hold select, output enable and the lane selects for the address access time. The bus is sampled in the last cycle of that window.
- **Writes** are strobe-controlled. They have a setup cycle, a low write pulse long enough for both the pulse-width and the address-to-end-of-write limits, and a recovery phase that fills out the minimum write cycle.
- **Bus hand-over.** When a write follows a read, the block waits out a bus release gap before it drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and straight after reset, all five memory strobes are high, the data bus is not driven, `req_ready` is high and `rsp_valid` is low.
- R2: A read with at least one lane enabled keeps select and output enable low, with the write strobe high, for RD_CYC cycles. RD_CYC is 4 with a 20 ns clock and grade 0. `req_ready` is low for those cycles. In the next cycle `rsp_valid` is high for exactly one cycle, and `rsp_rdata` holds the bus value sampled in the last strobed cycle.
- R3: A write with at least one lane enabled has three phases, with select low and output enable high throughout:
  - one setup cycle with the write strobe high;
  - PL_CYC cycles with the write strobe low (PL_CYC is 3 at the defaults);
  - REC_CYC cycles with the write strobe high again (REC_CYC is 1 at the defaults).

  The write data is driven on the bus for all three phases, and `req_ready` is low throughout.
- R4: Enable bit 0 maps to the lower-lane select, active low, which covers bus bits 7:0. Enable bit 1 maps to the upper-lane select, which covers bits 15:8. Only enabled lanes are written. On a read, the bits of a disabled lane return 0.
- R5: A request with both enables clear asserts no strobe and takes one cycle. For a read, `rsp_valid` rises in the next cycle with `rsp_rdata` equal to 0. A write of this kind returns nothing and leaves memory unchanged.
- R6: The block never drives the bus while output enable is low. A write that directly follows a read with enabled lanes is preceded by TA_CYC cycles with every strobe high and the bus released. TA_CYC is 2 at the defaults.
- R7: `sram_addr` changes only in a cycle in which chip select was high in the previous cycle.
- R8: `req_ready` is high exactly when no access is in progress, and a request is accepted on a clock edge where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| sram_addr | output | 17 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_dq | inout | 16 | Bidirectional data bus |

## Verification
A wrong phase state or a wrong count shows up at the strobe pins in the very cycle it goes wrong, because the bench predicts every strobe level and `req_ready` on every clock. A wrong lane mask or wrong captured data shows on `rsp_rdata` at the response strobe of the next read of that address. A missing release gap shows as a driven bus in the cycle after output enable rises.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS = 20,
  parameter int GRADE  = 0,
  parameter int AW     = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  inout  wire  [15:0]   sram_dq
);

  function automatic int ncyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int T_ACC   = (GRADE == 0) ? 70 : (GRADE == 1) ? 85 : 100;
  localparam int T_PULSE = (GRADE == 0) ? 50 : (GRADE == 1) ? 55 : 60;
  localparam int T_AEND  = (GRADE == 0) ? 55 : (GRADE == 1) ? 70 : 80;
  localparam int T_CYC   = (GRADE == 0) ? 70 : (GRADE == 1) ? 85 : 100;
  localparam int T_REL   = (GRADE == 0) ? 25 : (GRADE == 1) ? 30 : 35;
  localparam int RD_CYC  = ncyc(T_ACC);
  localparam int PL_CYC  = ncyc((T_AEND > T_PULSE) ? T_AEND : T_PULSE);
  localparam int WC_CYC  = ncyc(T_CYC);
  localparam int REC_CYC = (WC_CYC > PL_CYC + 1) ? WC_CYC - PL_CYC - 1 : 1;
  localparam int TA_CYC  = ncyc(T_REL);
  localparam int CNT_W   = $clog2(RD_CYC + PL_CYC + REC_CYC + TA_CYC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_RD, S_WSET, S_WPUL, S_WREC} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]   addr_q;
  logic [15:0]     wdata_q;
  logic [1:0]      be_q;
  logic            after_rd;
  logic            dq_drv;

  assign req_ready = (st == S_IDLE);
  assign sram_addr = addr_q;
  assign sram_cs_n = (st == S_IDLE) || (st == S_GAP);
  assign sram_oe_n = (st != S_RD);
  assign sram_we_n = (st != S_WPUL);
  assign sram_lb_n = sram_cs_n || !be_q[0];
  assign sram_ub_n = sram_cs_n || !be_q[1];
  assign dq_drv    = (st == S_WSET) || (st == S_WPUL) || (st == S_WREC);
  assign sram_dq   = dq_drv ? wdata_q : 16'hzzzz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      after_rd  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          if (req_be == 2'b00) begin
            if (!req_write) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end else if (req_write) begin
            after_rd <= 1'b0;
            if (after_rd) begin
              st  <= S_GAP;
              cnt <= CNT_W'(TA_CYC - 1);
            end else begin
              st <= S_WSET;
            end
          end else begin
            after_rd <= 1'b1;
            st       <= S_RD;
            cnt      <= CNT_W'(RD_CYC - 1);
          end
        end
        S_GAP:
          if (cnt == 0) st <= S_WSET;
          else cnt <= cnt - 1'b1;
        S_RD:
          if (cnt == 0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= sram_dq & {{8{be_q[1]}}, {8{be_q[0]}}};
            st        <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_WSET: begin
          st  <= S_WPUL;
          cnt <= CNT_W'(PL_CYC - 1);
        end
        S_WPUL:
          if (cnt == 0) begin
            st  <= S_WREC;
            cnt <= CNT_W'(REC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_WREC:
          if (cnt == 0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_oe_n)); // R3
  AST_LANE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_lb_n || !sram_ub_n) |-> !sram_cs_n); // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !dq_drv); // R6
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> !dq_drv); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr)); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && !dq_drv)); // R8

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int RD = 4, PL = 3, REC = 1, TA = 2;
  localparam int NDIR = 13, NOPS = 400;

  typedef struct packed {
    logic       rdy, cs, oe, we, lb, ub, drv, rsp;
    logic [15:0] dat;
    logic [3:0]  tag;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  wire  req_ready, rsp_valid;
  wire  [15:0] rsp_rdata;
  wire  [16:0] sram_addr;
  wire  sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
  wire  [15:0] sram_dq;

  always #10 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .sram_dq(sram_dq));

  logic [15:0] mem [256];
  logic [15:0] refm [256];
  wire  [7:0] midx = {sram_addr[16], sram_addr[6:0]};
  wire  bdrv = !sram_cs_n && !sram_oe_n && sram_we_n;
  assign sram_dq[7:0]  = (bdrv && !sram_lb_n) ? mem[midx][7:0]  : 8'hzz;
  assign sram_dq[15:8] = (bdrv && !sram_ub_n) ? mem[midx][15:8] : 8'hzz;

  always @(posedge sram_we_n) if (rst_n && !sram_cs_n) begin
    if (!sram_lb_n) mem[midx][7:0]  = sram_dq[7:0];
    if (!sram_ub_n) mem[midx][15:8] = sram_dq[15:8];
  end

  int compared = 0, mismatched = 0, cycles = 0, issued = 0;
  bit after_rd = 0, prev_cs_low = 0, done = 0;
  logic [16:0] prev_addr;
  ent_t q[$];

  function automatic string tname(logic [3:0] t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic ent_t mk(logic rdy, logic cs, logic oe, logic we, logic [1:0] be,
                              logic drv, logic rsp, logic [15:0] d, logic [3:0] t);
    ent_t e;
    e.rdy = rdy; e.cs = cs; e.oe = oe; e.we = we;
    e.lb = cs | ~be[0]; e.ub = cs | ~be[1];
    e.drv = drv; e.rsp = rsp; e.dat = d; e.tag = t;
    return e;
  endfunction

  task automatic pick(int k, output bit w, output logic [16:0] a, output logic [15:0] d,
                      output logic [1:0] be);
    d = 16'h0;
    case (k)
      0:  begin w = 1; a = 17'h5;     d = 16'hA55A; be = 2'b11; end
      1:  begin w = 0; a = 17'h5;     be = 2'b11; end
      2:  begin w = 1; a = 17'h5;     d = 16'h1234; be = 2'b01; end // R4 lower only
      3:  begin w = 1; a = 17'h5;     d = 16'hBE00; be = 2'b10; end // R4 upper only
      4:  begin w = 0; a = 17'h5;     be = 2'b01; end
      5:  begin w = 0; a = 17'h5;     be = 2'b10; end
      6:  begin w = 0; a = 17'h5;     be = 2'b00; end               // R5 empty read
      7:  begin w = 1; a = 17'h5;     d = 16'hFFFF; be = 2'b00; end // R5 empty write
      8:  begin w = 0; a = 17'h5;     be = 2'b11; end
      9:  begin w = 1; a = 17'h10003; d = 16'h0F0F; be = 2'b11; end
      10: begin w = 1; a = 17'h3;     d = 16'hC3C3; be = 2'b11; end
      11: begin w = 0; a = 17'h10003; be = 2'b11; end
      12: begin w = 0; a = 17'h3;     be = 2'b11; end
      default: begin
        w = $urandom_range(0, 1) == 1;
        a = {1'($urandom_range(0, 1)), 9'h0, 7'($urandom_range(0, 127))};
        d = 16'($urandom); be = 2'($urandom_range(0, 3));
      end
    endcase
  endtask

  task automatic issue();
    bit w; logic [16:0] a; logic [15:0] d; logic [1:0] be; logic [7:0] ix;
    pick(issued, w, a, d, be);
    issued++;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    ix = {a[16], a[6:0]};
    if (be == 2'b00) begin
      if (!w) q.push_back(mk(1, 1, 1, 1, 2'b00, 0, 1, 16'h0, 5));
    end else if (w) begin
      if (after_rd) for (int i = 0; i < TA; i++) q.push_back(mk(0, 1, 1, 1, 2'b00, 0, 0, 16'h0, 6));
      q.push_back(mk(0, 0, 1, 1, be, 1, 0, d, 3));
      for (int i = 0; i < PL; i++) q.push_back(mk(0, 0, 1, 0, be, 1, 0, d, 3));
      for (int i = 0; i < REC; i++) q.push_back(mk(0, 0, 1, 1, be, 1, 0, d, 3));
      if (be[0]) refm[ix][7:0] = d[7:0];
      if (be[1]) refm[ix][15:8] = d[15:8];
      after_rd = 0;
    end else begin
      for (int i = 0; i < RD; i++) q.push_back(mk(0, 0, 0, 1, be, 0, 0, 16'h0, 2));
      q.push_back(mk(1, 1, 1, 1, 2'b00, 0, 1, refm[ix] & {{8{be[1]}}, {8{be[0]}}}, 4));
      after_rd = 1;
    end
  endtask

  always @(negedge clk) if (!done) begin
    ent_t e;
    cycles++;
    if (!rst_n) begin // R1
      chk({req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, rsp_valid} == 7'b1111110,
          "R1", "reset strobes", {25'h0, req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, rsp_valid},
          32'h7E);
      chk(sram_dq === 16'hzzzz, "R1", "bus released in reset", {16'h0, sram_dq}, 32'h0);
    end else begin
      e = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 1, 2'b00, 0, 0, 16'h0, 8);
      chk({req_ready, sram_cs_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, rsp_valid} ===
          {e.rdy, e.cs, e.oe, e.we, e.lb, e.ub, e.rsp}, tname(e.tag), "ready/strobes/rsp",
          {25'h0, req_ready, sram_cs_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, rsp_valid},
          {25'h0, e.rdy, e.cs, e.oe, e.we, e.lb, e.ub, e.rsp});
      if (e.rsp) chk(rsp_rdata === e.dat, tname(e.tag), "read data", {16'h0, rsp_rdata}, {16'h0, e.dat});
      if (e.drv) chk(sram_dq === e.dat, "R3", "write bus", {16'h0, sram_dq}, {16'h0, e.dat});
      else if (e.oe) chk(sram_dq === 16'hzzzz, "R6", "bus released", {16'h0, sram_dq}, 32'h0);
      if (!sram_cs_n && prev_cs_low)
        chk(sram_addr === prev_addr, "R7", "address held under select", {15'h0, sram_addr}, {15'h0, prev_addr});
      prev_cs_low = !sram_cs_n;
      prev_addr = sram_addr;
      req_valid = 0;
      if (e.rdy && issued < NOPS) issue(); // R8 accepted only when ready
      if (issued >= NOPS && q.size() == 0 && !req_valid) begin
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
    if (cycles > 150000) begin
      done = 1;
      mismatched++;
      $display("FAIL R8 watchdog: got %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; refm[i] = 16'h0; end
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
  end
endmodule